// File: doc/BRIEF.md
# Dual-Mode Split Exponent Adder

This block forms the biased exponent of a product for a floating-point multiplier that works either on one double-precision pair or on two single-precision pairs packed in the same 64-bit words. A mode input picks the exponent fields and the bias constant. The two exponents and the negated bias are first reduced to two words by a carry-save row. A 16-bit two-level carry-lookahead adder then adds them. In double mode that adder acts as one wide lane. In single mode it is cut at bit 8 into two independent 8-bit lanes.

For every lane the block returns the low bits of the biased sum and a two-bit wrap count. The wrap count tells the following stage whether the true value fell below zero, lies inside the lane, or went past it. One register stage sits on the output so the block lines up with the first stage of a two-stage multiplier. A valid flag and the mode travel through that register with the data.

Top module: `simd_exp_adder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state has `out_valid`, `out_dbl`, `res_exp`, `wrap_lo` and `wrap_hi` all zero.
- R2: `out_valid` is `in_valid` delayed by one clock. When `out_valid` is high, `out_dbl` equals the `dbl_mode` value applied with that input.
- R3: In double mode (`dbl_mode`=1) the exponents are bits 62:52 of each operand. `res_exp` is ea+eb-1023 as a 16-bit two's-complement value.
- R4: In double mode `wrap_hi` is 1 when ea+eb >= 1023 and 0 otherwise, and `wrap_lo` is 0.
- R5: In single mode (`dbl_mode`=0) the high lane takes bits 62:55 and the low lane takes bits 30:23 of each operand. `res_exp[15:8]` and `res_exp[7:0]` are (ea+eb-127) mod 256 for their own lane.
- R6: In single mode each lane's wrap count is floor((ea+eb+129)/256). The value 0 means the result is below zero, 1 means it is in 0..255, and 2 means it is 256 or more.
- R7: In single mode nothing from the low lane, including a carry out of bit 7, changes the high lane's result or wrap count.
- R8: Operand bits outside the selected exponent fields (signs and mantissas) have no effect on any output.
- R9: When `in_valid` is low at a clock edge, `res_exp`, `wrap_lo` and `wrap_hi` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair is present this cycle |
| dbl_mode | input | 1 | 1 = one double-precision lane, 0 = two single-precision lanes |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Registered result is valid |
| out_dbl | output | 1 | Mode that goes with the registered result |
| res_exp | output | 16 | Biased sum: one 16-bit value, or high lane in [15:8] and low lane in [7:0] |
| wrap_lo | output | 2 | Wrap count of the low single lane (0 in double mode) |
| wrap_hi | output | 2 | Wrap count of the high lane or of the double lane |

## Verification
The assertions assume that `dbl_mode` and the exponent fields of both operands hold known values in every cycle where `in_valid` is high. They also assume that the mode is read only together with the valid flag, so a mode change between transfers is legal and carries no meaning of its own. The stimulus changes every input only on the falling clock edge. It fills the non-exponent bits with random data and switches mode freely between transfers, including back-to-back ones. Directed cases drive lane sums around 127 and 383 and double sums around 1023. They also force a low-lane carry out of bit 7 while the high lane sits at its smallest sum.

// File: rtl/fpexp_pkg.sv
`timescale 1ns/1ps
// Shared geometry of the packed operands and the split exponent adder.
// Assumes double fields of 11 bits and single fields of 8 bits.
package fpexp_pkg;
    localparam int OPW       = 64;  // packed operand width
    localparam int ADW       = 16;  // split adder width
    localparam int LANEW     = 8;   // single lane width, also the split point
    localparam int DEXPW     = 11;  // double exponent width
    localparam int GRPW      = 4;   // first-level lookahead group width
    localparam int D_LSB     = 52;  // double exponent field lsb
    localparam int SH_LSB    = 55;  // high single exponent field lsb
    localparam int SL_LSB    = 23;  // low single exponent field lsb
    localparam int DBIAS     = 1023;
    localparam int SBIAS     = 127;
endpackage

// File: rtl/exp_lcg.sv
`timescale 1ns/1ps
// Lookahead carry group: from per-position generate/propagate and a
// carry-in it gives the carry into each position plus group G/P.
// Used for both levels of the adder; no state.
module exp_lcg #(
    parameter int W = 4
) (
    input  logic [W-1:0] g,
    input  logic [W-1:0] p,
    input  logic         cin,
    output logic [W-1:0] c,
    output logic         gg,
    output logic         gp
);
    // Carries inside the group and the group generate/propagate terms.
    always_comb begin
        logic run;
        run = cin;
        for (int i = 0; i < W; i++) begin
            c[i] = run;
            run  = g[i] | (p[i] & run);
        end
        gg = 1'b0;
        gp = 1'b1;
        for (int i = 0; i < W; i++) begin
            gg = g[i] | (p[i] & gg);
            gp = gp & p[i];
        end
    end
endmodule

// File: rtl/exp_operand_prep.sv
`timescale 1ns/1ps
// Places the exponent fields and the negated bias on the adder columns,
// then reduces the three words to two with a carry-save row.
// In single mode the majority bit out of the low lane is not shifted
// into the high lane; it is reported as the low lane's dropped weight.
module exp_operand_prep
    import fpexp_pkg::*;
#(
    parameter int AW = ADW,
    parameter int LW = LANEW,
    parameter int DW = DEXPW
) (
    input  logic          dbl,
    input  logic [DW-1:0] a_d,
    input  logic [DW-1:0] b_d,
    input  logic [LW-1:0] a_h,
    input  logic [LW-1:0] b_h,
    input  logic [LW-1:0] a_l,
    input  logic [LW-1:0] b_l,
    output logic [AW-1:0] s_w,
    output logic [AW-1:0] c_w,
    output logic          drop_lo,
    output logic          drop_hi
);
    localparam logic [AW-1:0] D_NEG = AW'(-DBIAS);
    localparam logic [LW-1:0] S_NEG = LW'(-SBIAS);

    logic [AW-1:0] x, y, z, maj;

    // Column placement of both exponents and the bias for the active mode.
    always_comb begin
        if (dbl) begin
            x = AW'(a_d);
            y = AW'(b_d);
            z = D_NEG;
        end else begin
            x = {a_h, a_l};
            y = {b_h, b_l};
            z = {S_NEG, S_NEG};
        end
    end

    // 3:2 reduction; the lane boundary blocks the shifted majority bit.
    always_comb begin
        s_w = x ^ y ^ z;
        maj = (x & y) | (x & z) | (y & z);
        c_w = {maj[AW-2:0], 1'b0};
        c_w[LW] = maj[LW-1] & dbl;
        drop_lo = maj[LW-1] & ~dbl;
        drop_hi = maj[AW-1];
    end
endmodule

// File: rtl/split_cla.sv
`timescale 1ns/1ps
// Two-level carry-lookahead adder that the mode bit can cut at SPLIT.
// With dbl low the propagate at SPLIT and the carry used in its sum
// are forced to zero, giving two independent lanes.
module split_cla #(
    parameter int AW    = 16,
    parameter int GW    = 4,
    parameter int SPLIT = 8
) (
    input  logic          dbl,
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic          cin,
    output logic [AW-1:0] sum,
    output logic          c_split,
    output logic          cout
);
    localparam int NG = AW / GW;

    logic [AW-1:0] g, h, p, c, cm;
    logic [NG-1:0] grp_g, grp_p, grp_c;
    logic          top_g, top_p;

    // Bit generate, half sum, and propagate with the lane cut applied.
    always_comb begin
        g = a & b;
        h = a ^ b;
        p = h;
        p[SPLIT] = h[SPLIT] & dbl;
    end

    for (genvar gi = 0; gi < NG; gi++) begin : g_lvl1
        exp_lcg #(.W(GW)) u_grp (
            .g   (g[gi*GW +: GW]),
            .p   (p[gi*GW +: GW]),
            .cin (grp_c[gi]),
            .c   (c[gi*GW +: GW]),
            .gg  (grp_g[gi]),
            .gp  (grp_p[gi])
        );
    end

    exp_lcg #(.W(NG)) u_lvl2 (
        .g   (grp_g),
        .p   (grp_p),
        .cin (cin),
        .c   (grp_c),
        .gg  (top_g),
        .gp  (top_p)
    );

    // Sum bits; the carry into the split column counts only in wide mode.
    always_comb begin
        cm = c;
        cm[SPLIT] = c[SPLIT] & dbl;
        sum = h ^ cm;
        c_split = c[SPLIT];
        cout = top_g | (top_p & cin);
    end
endmodule

// File: rtl/simd_exp_adder.sv
`timescale 1ns/1ps
// Product exponent adder for a multiplier with one double lane or two
// single lanes. Picks fields, adds the negated bias by carry-save, sums
// on the split adder and registers result, wrap counts, mode and valid.
// Assumes inputs are known whenever in_valid is high.
module simd_exp_adder
    import fpexp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            dbl_mode,
    input  logic [OPW-1:0]  op_a,
    input  logic [OPW-1:0]  op_b,
    output logic            out_valid,
    output logic            out_dbl,
    output logic [ADW-1:0]  res_exp,
    output logic [1:0]      wrap_lo,
    output logic [1:0]      wrap_hi
);
    logic [ADW-1:0] s_w, c_w, sum;
    logic           drop_lo, drop_hi, c_split, cout;
    logic [1:0]     wlo_n, whi_n;
    logic           unused_bits;

    assign unused_bits = ^{op_a[OPW-1], op_a[D_LSB-1:SL_LSB+LANEW], op_a[SL_LSB-1:0],
                           op_b[OPW-1], op_b[D_LSB-1:SL_LSB+LANEW], op_b[SL_LSB-1:0]};

    exp_operand_prep #(.AW(ADW), .LW(LANEW), .DW(DEXPW)) u_prep (
        .dbl     (dbl_mode),
        .a_d     (op_a[D_LSB +: DEXPW]),
        .b_d     (op_b[D_LSB +: DEXPW]),
        .a_h     (op_a[SH_LSB +: LANEW]),
        .b_h     (op_b[SH_LSB +: LANEW]),
        .a_l     (op_a[SL_LSB +: LANEW]),
        .b_l     (op_b[SL_LSB +: LANEW]),
        .s_w     (s_w),
        .c_w     (c_w),
        .drop_lo (drop_lo),
        .drop_hi (drop_hi)
    );

    split_cla #(.AW(ADW), .GW(GRPW), .SPLIT(LANEW)) u_cla (
        .dbl     (dbl_mode),
        .a       (s_w),
        .b       (c_w),
        .cin     (1'b0),
        .sum     (sum),
        .c_split (c_split),
        .cout    (cout)
    );

    // Wrap counts: adder carry-out plus the weight the carry-save row dropped.
    always_comb begin
        wlo_n = dbl_mode ? 2'd0 : ({1'b0, c_split} + {1'b0, drop_lo});
        whi_n = {1'b0, cout} + {1'b0, drop_hi};
    end

    // Output stage: valid every cycle, data only on accepted inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_dbl   <= 1'b0;
            res_exp   <= '0;
            wrap_lo   <= 2'd0;
            wrap_hi   <= 2'd0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_dbl <= dbl_mode;
                res_exp <= sum;
                wrap_lo <= wlo_n;
                wrap_hi <= whi_n;
            end
        end
    end
endmodule

// File: rtl/simd_exp_adder_chk.sv
`timescale 1ns/1ps
// Port-level properties of the split exponent adder, bound to the top.
module simd_exp_adder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        dbl_mode,
    input logic [63:0] op_a,
    input logic [63:0] op_b,
    input logic        out_valid,
    input logic        out_dbl,
    input logic [15:0] res_exp,
    input logic [1:0]  wrap_lo,
    input logic [1:0]  wrap_hi
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!out_valid && res_exp == 16'd0)); // R1
    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
    AST_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_dbl == $past(dbl_mode)); // R2
    AST_DBL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dbl_mode) |=> res_exp == $past(16'(op_a[62:52]) + 16'(op_b[62:52]) + 16'hFC01)); // R3
    AST_DBL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dbl) |-> (wrap_lo == 2'd0 && wrap_hi <= 2'd1)); // R4
    AST_LANE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_dbl) |-> (wrap_lo != 2'd3 && wrap_hi != 2'd3)); // R6
    AST_HI_LANE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dbl_mode) |=> res_exp[15:8] == $past(op_a[62:55] + op_b[62:55] + 8'h81)); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_exp) && $stable(wrap_hi) && $stable(wrap_lo))); // R9
endmodule

bind simd_exp_adder simd_exp_adder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dbl_mode(dbl_mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_dbl(out_dbl),
    .res_exp(res_exp), .wrap_lo(wrap_lo), .wrap_hi(wrap_hi)
);

// File: tb/simd_exp_adder_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected results, the monitor
// compares them one clock later, a quarter period after the edge.
module simd_exp_adder_test;
    typedef struct {
        logic        dbl;
        logic [15:0] res;
        logic [1:0]  wlo;
        logic [1:0]  whi;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dbl_mode = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        out_valid, out_dbl;
    logic [15:0] res_exp;
    logic [1:0]  wrap_lo, wrap_hi;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    simd_exp_adder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dbl_mode(dbl_mode),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_dbl(out_dbl),
        .res_exp(res_exp), .wrap_lo(wrap_lo), .wrap_hi(wrap_hi)
    );

    function automatic logic [63:0] fill();
        return {$urandom, $urandom};
    endfunction

    // Send one double-precision pair; non-field bits random (R8).
    task automatic send_dbl(input int ea, input int eb, input string req);
        exp_t e;
        int   t;
        @(negedge clk);
        op_a = fill(); op_b = fill();
        op_a[62:52] = 11'(ea); op_b[62:52] = 11'(eb);
        dbl_mode = 1'b1; in_valid = 1'b1;
        t = ea + eb - 1023;
        e.dbl = 1'b1; e.res = 16'(t); e.wlo = 2'd0;
        e.whi = (ea + eb >= 1023) ? 2'd1 : 2'd0;   // R4
        e.req = req;
        sb.push_back(e);
    endtask

    // Send two single-precision pairs; non-field bits random (R8).
    task automatic send_sgl(input int ah, input int bh, input int al, input int bl,
                            input string req);
        exp_t e;
        int   th, tl;
        @(negedge clk);
        op_a = fill(); op_b = fill();
        op_a[62:55] = 8'(ah); op_b[62:55] = 8'(bh);
        op_a[30:23] = 8'(al); op_b[30:23] = 8'(bl);
        dbl_mode = 1'b0; in_valid = 1'b1;
        th = ah + bh + 129; tl = al + bl + 129;
        e.dbl = 1'b0;
        e.res = {8'(th), 8'(tl)};
        e.whi = 2'(th / 256); e.wlo = 2'(tl / 256);   // R6
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_a = fill(); op_b = fill(); dbl_mode = ~dbl_mode;
        end
    endtask

    // Monitor: pop and compare on valid, check the hold on idle cycles.
    initial begin : monitor
        logic [15:0] last_res;
        logic [1:0]  last_wlo, last_whi;
        bit          have_last;
        exp_t        e;
        have_last = 0;
        last_res = '0; last_wlo = '0; last_whi = '0;
        @(posedge rst_n);
        forever begin
            @(posedge clk); #5;
            if (out_valid) begin
                n_checks++;
                if (sb.size() == 0) begin
                    n_fail++;
                    $display("FAIL R2: out_valid=1 with no pending input, expected 0");
                end else begin
                    e = sb.pop_front();
                    if (out_dbl !== e.dbl || res_exp !== e.res ||
                        wrap_lo !== e.wlo || wrap_hi !== e.whi) begin
                        n_fail++;
                        $display("FAIL %s: dbl=%0b res=%h wlo=%0d whi=%0d, expected dbl=%0b res=%h wlo=%0d whi=%0d",
                                 e.req, out_dbl, res_exp, wrap_lo, wrap_hi,
                                 e.dbl, e.res, e.wlo, e.whi);
                    end
                end
                last_res = res_exp; last_wlo = wrap_lo; last_whi = wrap_hi;
                have_last = 1;
            end else if (have_last) begin
                n_checks++;
                if (res_exp !== last_res || wrap_lo !== last_wlo || wrap_hi !== last_whi) begin
                    n_fail++;
                    $display("FAIL R9: res=%h wlo=%0d whi=%0d, expected held res=%h wlo=%0d whi=%0d",
                             res_exp, wrap_lo, wrap_hi, last_res, last_wlo, last_whi);
                end
            end
        end
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        n_checks++;   // R1 reset state
        if (out_valid !== 1'b0 || res_exp !== 16'd0 || wrap_lo !== 2'd0 ||
            wrap_hi !== 2'd0 || out_dbl !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: valid=%0b res=%h wlo=%0d whi=%0d, expected all zero",
                     out_valid, res_exp, wrap_lo, wrap_hi);
        end
        @(negedge clk); rst_n = 1'b1;

        // Double lane corners (R3, R4)
        send_dbl(1023, 0, "R3");
        send_dbl(0, 0, "R4");
        send_dbl(2047, 2047, "R3");
        send_dbl(1022, 0, "R4");
        send_dbl(512, 511, "R4");
        idle(2);
        // Single lanes: low lane carries past bit 7, high lane minimal (R7)
        send_sgl(0, 0, 255, 255, "R7");
        send_sgl(127, 0, 200, 100, "R5");
        send_sgl(255, 255, 0, 0, "R6");
        send_sgl(126, 0, 127, 0, "R6");
        send_sgl(128, 255, 1, 126, "R5");
        // Mode swaps back to back (R2)
        send_dbl(1500, 700, "R2");
        send_sgl(64, 64, 255, 129, "R2");
        idle(1);
        // Random traffic, random fill outside the fields (R8)
        for (int i = 0; i < 120; i++) begin
            if (($urandom % 2) == 0)
                send_dbl(int'($urandom % 2048), int'($urandom % 2048), "R8");
            else
                send_sgl(int'($urandom % 256), int'($urandom % 256),
                         int'($urandom % 256), int'($urandom % 256), "R8");
            if (($urandom % 5) == 0) idle(1 + int'($urandom % 3));
        end
        idle(4);
        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R2: %0d results missing, expected 0", sb.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule